// File: doc/BRIEF.md
# Frame-Clock Synchronization Loss Muting Controller

This block watches where the audio frame clock (the left/right word clock) lands relative to a bit-clock reference that runs freely in the system clock domain. On every rising edge of the frame clock it captures the reference position. It then compares that value with the position captured on the previous rising edge. If the phase stays fixed, or wanders by only a few bit clocks, the link is treated as synchronized. A larger jump within one sample period is a loss of synchronization.

On a loss, both converter directions are muted: the word sent toward the DAC and the code coming back from the ADC are both replaced by bipolar zero, which is the two's-complement value 0. Recovery needs two consecutive frames whose phase matches within tolerance. After that, the status flag returns high, but the outputs stay at zero for a further fixed number of sample periods before live data is released. A new loss at any point starts the whole recovery sequence again.

The bit clock and frame clock are taken as level inputs that are synchronous to the system clock and much slower than it. All sequential logic runs on the system clock and uses a synchronous active-low reset.

Top module: `frame_sync_mute`

## Requirements
- R1: While reset is low and in the cycle after it is released, `sync_ok` is 0 and both outputs are 0. Reset also discards the stored phase, so the first frame-clock rising edge after reset is only recorded and is never compared with a value from before reset.
- R2: The phase is the count of bit-clock rising edges modulo BITS_PER_FRAME (default 64), taken at each frame-clock rising edge. The drift is the circular distance between two consecutive phases. A drift of 0 to 6 bit clocks in either direction, 6 included, leaves `sync_ok` high and the data unmuted.
- R3: A drift of 7 bit clocks or more in either direction drops `sync_ok` to 0 within a few system clocks of that frame-clock edge.
- R4: While `sync_ok` is 0, `dac_out` and `adc_out` are both 0 (two's-complement bipolar zero) from the next system-clock cycle on.
- R5: After a loss, or after reset, `sync_ok` returns to 1 on the second consecutive frame-clock edge whose drift is within tolerance.
- R6: After `sync_ok` returns, the outputs stay at 0 until 32 (HOLD_FRAMES) further frame-clock rising edges have occurred. They are released after the 32nd edge.
- R7: A loss that happens during the hold period clears `sync_ok` and restarts recovery. A fresh two-frame lock and a fresh full 32-frame hold are needed before release.
- R8: When the path is released, `dac_out` and `adc_out` each equal their own input from the previous system clock. The two paths are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Bit clock, sampled on sys_clk |
| lrclk | input | 1 | Frame (left/right) clock, sampled on sys_clk |
| dac_in | input | SAMPLE_W | Signed sample headed for the DAC |
| adc_in | input | SAMPLE_W | Signed code produced by the ADC |
| dac_out | output | SAMPLE_W | DAC sample, zero while muted |
| adc_out | output | SAMPLE_W | ADC code, zero while muted |
| sync_ok | output | 1 | High while frame clock phase is locked |

## Verification
On every cycle, the assertions check the following: outputs are zero while the status is low, a detected phase jump always leaves the status low, the hold counter stays within its bound, released data follows the inputs, and the reset state is muted. Some behaviour can only be shown by the bench's frame sequences. These are the exact tolerance boundary of 6 against 7 bit clocks in both directions, the two-frame lock count, and the exact 32-edge length of the hold and its restart. Those sequences stretch and shrink individual frames to move the phase.

// File: rtl/fsm_pkg.sv
// Package: shared defaults and the circular phase distance helper for the
// frame-clock sync muting controller. Assumes phases are below the modulus.
package fsm_pkg;
    localparam int unsigned DEF_BITS_PER_FRAME = 64;
    localparam int unsigned DEF_DRIFT_TOL      = 6;
    localparam int unsigned DEF_HOLD_FRAMES    = 32;
    localparam int unsigned DEF_LOCK_FRAMES    = 2;
    localparam int unsigned DEF_SAMPLE_W       = 16;

    // Shortest distance between two positions on a ring of size modulus.
    function automatic int unsigned circ_drift(input int unsigned cur,
                                               input int unsigned prev,
                                               input int unsigned modulus);
        int unsigned d;
        d = (cur >= prev) ? (cur - prev) : (cur + modulus - prev);
        return (d > modulus / 2) ? (modulus - d) : d;
    endfunction
endpackage

// File: rtl/fsm_edge_rise.sv
// Rising-edge detectors for a bundle of slow level inputs.
// Assumes every input is synchronous to clk and held for at least two clocks.
module fsm_edge_rise #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // Remember the last sampled level of one input.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= lvl[g];
        end
        // High for one clock when the input goes from 0 to 1.
        assign rise[g] = lvl[g] & ~prev_q[g];
    end
endmodule

// File: rtl/fsm_phase_ref.sv
// Free-running bit-clock reference: counts bit-clock rising edges modulo
// BITS_PER_FRAME in the system clock domain. Assumes bit_rise is a one-clock pulse.
module fsm_phase_ref #(
    parameter int unsigned BITS_PER_FRAME = 64,
    localparam int unsigned PH_W = $clog2(BITS_PER_FRAME)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_rise,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(BITS_PER_FRAME - 1);

    // Advance and wrap the reference on each bit-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase <= '0;
        else if (bit_rise) phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/fsm_lock_monitor.sv
// Lock monitor: captures the reference phase at each frame-clock edge, compares
// it with the previous capture and tracks lock. Emits one-clock loss and
// relock pulses. Assumes frame_rise is a one-clock pulse.
module fsm_lock_monitor
    import fsm_pkg::*;
#(
    parameter int unsigned BITS_PER_FRAME = 64,
    parameter int unsigned DRIFT_TOL      = 6,
    parameter int unsigned LOCK_FRAMES    = 2,
    localparam int unsigned PH_W = $clog2(BITS_PER_FRAME),
    localparam int unsigned LC_W = $clog2(LOCK_FRAMES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_rise,
    input  logic [PH_W-1:0] phase_now,
    output logic            in_sync,
    output logic            loss_evt,
    output logic            relock_evt
);
    localparam logic [LC_W-1:0] LOCK_N = LC_W'(LOCK_FRAMES);

    logic [PH_W-1:0] last_phase;
    logic            have_prev;
    logic [LC_W-1:0] match_cnt;
    logic            too_far;

    // Compare the new capture against the previous one.
    always_comb begin
        too_far = circ_drift(32'(phase_now), 32'(last_phase), BITS_PER_FRAME) > DRIFT_TOL;
    end

    // Store phase, count matching frames and update the lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_phase <= '0;
            have_prev  <= 1'b0;
            match_cnt  <= '0;
            in_sync    <= 1'b0;
            loss_evt   <= 1'b0;
            relock_evt <= 1'b0;
        end else begin
            loss_evt   <= 1'b0;
            relock_evt <= 1'b0;
            if (frame_rise) begin
                last_phase <= phase_now;
                have_prev  <= 1'b1;
                if (!have_prev) begin
                    match_cnt <= '0;
                end else if (too_far) begin
                    match_cnt <= '0;
                    in_sync   <= 1'b0;
                    loss_evt  <= 1'b1;
                end else if (match_cnt < LOCK_N) begin
                    match_cnt <= match_cnt + 1'b1;
                    if (!in_sync && (match_cnt + 1'b1 == LOCK_N)) begin
                        in_sync    <= 1'b1;
                        relock_evt <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fsm_mute_gate.sv
// Mute gate: counts the post-relock hold in frame periods and forces both
// sample paths to two's-complement zero while unlocked or holding.
module fsm_mute_gate #(
    parameter int unsigned HOLD_FRAMES = 32,
    parameter int unsigned SAMPLE_W    = 16,
    localparam int unsigned HC_W = $clog2(HOLD_FRAMES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_rise,
    input  logic                in_sync,
    input  logic                loss_evt,
    input  logic                relock_evt,
    input  logic [SAMPLE_W-1:0] dac_in,
    input  logic [SAMPLE_W-1:0] adc_in,
    output logic [SAMPLE_W-1:0] dac_out,
    output logic [SAMPLE_W-1:0] adc_out,
    output logic [HC_W-1:0]     hold_cnt
);
    localparam logic [HC_W-1:0] HOLD_N = HC_W'(HOLD_FRAMES);

    logic mute;

    // Load the hold on loss or relock and count it down on frame edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       hold_cnt <= HOLD_N;
        else if (loss_evt || relock_evt)                  hold_cnt <= HOLD_N;
        else if (frame_rise && in_sync && hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end

    // Mute while out of lock or while the hold is still running.
    assign mute = !in_sync || (hold_cnt != '0);

    // Register both outputs with bipolar zero substituted while muted.
    always_ff @(posedge clk) begin
        if (!rst_n || mute) begin
            dac_out <= '0;
            adc_out <= '0;
        end else begin
            dac_out <= dac_in;
            adc_out <= adc_in;
        end
    end
endmodule

// File: rtl/frame_sync_mute.sv
// Top: frame-clock synchronization loss muting controller. Assumes bclk and
// lrclk are synchronous to sys_clk and change at most every second clock.
module frame_sync_mute
    import fsm_pkg::*;
#(
    parameter int unsigned BITS_PER_FRAME = DEF_BITS_PER_FRAME,
    parameter int unsigned DRIFT_TOL      = DEF_DRIFT_TOL,
    parameter int unsigned HOLD_FRAMES    = DEF_HOLD_FRAMES,
    parameter int unsigned LOCK_FRAMES    = DEF_LOCK_FRAMES,
    parameter int unsigned SAMPLE_W       = DEF_SAMPLE_W
) (
    input  logic                sys_clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                lrclk,
    input  logic [SAMPLE_W-1:0] dac_in,
    input  logic [SAMPLE_W-1:0] adc_in,
    output logic [SAMPLE_W-1:0] dac_out,
    output logic [SAMPLE_W-1:0] adc_out,
    output logic                sync_ok
);
    localparam int unsigned PH_W = $clog2(BITS_PER_FRAME);
    localparam int unsigned HC_W = $clog2(HOLD_FRAMES + 1);

    logic [1:0]      rises;
    logic [PH_W-1:0] ref_phase;
    logic            loss_evt;
    logic            relock_evt;
    logic [HC_W-1:0] hold_cnt;

    fsm_edge_rise #(.N(2)) edge_i (
        .clk(sys_clk), .rst_n(rst_n), .lvl({lrclk, bclk}), .rise(rises)
    );

    fsm_phase_ref #(.BITS_PER_FRAME(BITS_PER_FRAME)) ref_i (
        .clk(sys_clk), .rst_n(rst_n), .bit_rise(rises[0]), .phase(ref_phase)
    );

    fsm_lock_monitor #(
        .BITS_PER_FRAME(BITS_PER_FRAME), .DRIFT_TOL(DRIFT_TOL), .LOCK_FRAMES(LOCK_FRAMES)
    ) mon_i (
        .clk(sys_clk), .rst_n(rst_n), .frame_rise(rises[1]), .phase_now(ref_phase),
        .in_sync(sync_ok), .loss_evt(loss_evt), .relock_evt(relock_evt)
    );

    fsm_mute_gate #(.HOLD_FRAMES(HOLD_FRAMES), .SAMPLE_W(SAMPLE_W)) gate_i (
        .clk(sys_clk), .rst_n(rst_n), .frame_rise(rises[1]), .in_sync(sync_ok),
        .loss_evt(loss_evt), .relock_evt(relock_evt), .dac_in(dac_in), .adc_in(adc_in),
        .dac_out(dac_out), .adc_out(adc_out), .hold_cnt(hold_cnt)
    );
endmodule

// File: rtl/frame_sync_mute_chk.sv
// Checker bound to the top: clocked properties over ports and internal events.
module frame_sync_mute_chk #(
    parameter int unsigned HOLD_FRAMES = 32,
    parameter int unsigned SAMPLE_W    = 16,
    localparam int unsigned HC_W = $clog2(HOLD_FRAMES + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sync_ok,
    input logic                loss_evt,
    input logic [HC_W-1:0]     hold_cnt,
    input logic [SAMPLE_W-1:0] dac_in,
    input logic [SAMPLE_W-1:0] adc_in,
    input logic [SAMPLE_W-1:0] dac_out,
    input logic [SAMPLE_W-1:0] adc_out
);
    AST_RESET_MUTED: assert property (@(posedge clk) !rst_n |=> (!sync_ok && dac_out == '0 && adc_out == '0)); // R1
    AST_LOSS_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n) loss_evt |-> !sync_ok); // R3
    AST_UNLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !sync_ok |=> (dac_out == '0 && adc_out == '0)); // R4
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n) hold_cnt <= HC_W'(HOLD_FRAMES)); // R6
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ok && hold_cnt == '0) |=> (dac_out == $past(dac_in) && adc_out == $past(adc_in))); // R8
endmodule

bind frame_sync_mute frame_sync_mute_chk #(.HOLD_FRAMES(HOLD_FRAMES), .SAMPLE_W(SAMPLE_W)) chk_i (
    .clk(sys_clk), .rst_n(rst_n), .sync_ok(sync_ok), .loss_evt(loss_evt), .hold_cnt(hold_cnt),
    .dac_in(dac_in), .adc_in(adc_in), .dac_out(dac_out), .adc_out(adc_out)
);

// File: tb/frame_sync_mute_tb_top.sv
// Bench: frame-length vectors move the frame-clock phase; lock and mute
// results are checked after each group of frames, then directed tests follow.
module frame_sync_mute_tb_top;
    localparam int NROW = 17;
    // Each row: frame length in bits, repeat count, expected sync_ok, expected mute.
    // A frame of 64+k bits moves the following frame edge by k bit clocks.
    localparam int LEN  [NROW] = '{64, 64, 64, 64, 70, 64, 71, 64, 64, 64, 64, 57, 64, 64, 64, 58, 64};
    localparam int REP  [NROW] = '{ 1,  2, 31,  1,  1,  1,  1,  1,  1,  1, 20,  1,  1,  2, 32,  1,  1};
    localparam bit ESYN [NROW] = '{ 0,  1,  1,  1,  1,  1,  1,  0,  0,  1,  1,  1,  0,  1,  1,  1,  1};
    localparam bit EMUT [NROW] = '{ 1,  1,  1,  0,  0,  0,  0,  1,  1,  1,  1,  1,  1,  1,  0,  0,  0};

    logic        sys_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        bclk    = 1'b0;
    logic        lrclk   = 1'b0;
    logic [15:0] dac_in  = 16'h1234;
    logic [15:0] adc_in  = 16'hA5C3;
    logic [15:0] dac_out;
    logic [15:0] adc_out;
    logic        sync_ok;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 sys_clk = ~sys_clk;

    frame_sync_mute dut_i (
        .sys_clk(sys_clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
        .dac_in(dac_in), .adc_in(adc_in), .dac_out(dac_out), .adc_out(adc_out),
        .sync_ok(sync_ok)
    );

    function automatic string row_req(input int i);
        case (i)
            0, 1:     return "R5";
            2, 3:     return "R6";
            4, 5:     return "R2";
            6, 7:     return "R3";
            8, 9:     return "R5";
            10, 11:   return "R2";
            12, 13:   return "R7";
            14:       return "R7";
            default:  return "R2";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    // One frame: frame clock high for the first half; each bit is 2 clocks high, 2 low.
    task automatic frame(input int len);
        for (int b = 0; b < len; b++) begin
            @(negedge sys_clk);
            bclk = 1'b1;
            wait_clk(2);
            bclk  = 1'b0;
            lrclk = (b < len / 2);
            wait_clk(1);
        end
        @(negedge sys_clk);
    endtask

    task automatic check_out(input string req, input bit muted);
        check(req, "dac_out", int'(dac_out), muted ? 0 : int'(dac_in));
        check(req, "adc_out", int'(adc_out), muted ? 0 : int'(adc_in));
    endtask

    initial begin
        wait_clk(4);
        // R1: reset state with live nonzero inputs.
        check("R1", "sync_ok in reset", int'(sync_ok), 0);
        check_out("R1", 1'b1);
        rst_n = 1'b1;
        wait_clk(1);
        check("R1", "sync_ok after reset", int'(sync_ok), 0);
        check_out("R1", 1'b1);

        for (int i = 0; i < NROW; i++) begin
            for (int r = 0; r < REP[i]; r++) frame(LEN[i]);
            wait_clk(3);
            check(row_req(i), $sformatf("sync_ok row %0d", i), int'(sync_ok), int'(ESYN[i]));
            check_out(EMUT[i] ? "R4" : "R8", EMUT[i]);
        end

        // R8: independent pass-through of distinct values, one clock latency.
        dac_in = 16'h8001;
        adc_in = 16'h7FFE;
        wait_clk(2);
        check("R8", "dac_out new value", int'(dac_out), 16'h8001);
        check("R8", "adc_out new value", int'(adc_out), 16'h7FFE);
        dac_in = 16'h0000;
        adc_in = 16'hFFFF;
        wait_clk(2);
        check("R8", "dac_out zero input", int'(dac_out), 0);
        check("R8", "adc_out all ones", int'(adc_out), 16'hFFFF);

        // R1: reset in mid-run mutes at once and forgets the stored phase.
        rst_n = 1'b0;
        wait_clk(2);
        check("R1", "sync_ok mid-run reset", int'(sync_ok), 0);
        check_out("R1", 1'b1);
        rst_n = 1'b1;
        frame(64);
        wait_clk(3);
        check("R1", "sync_ok first frame after reset", int'(sync_ok), 0);
        frame(64);
        wait_clk(3);
        check("R5", "sync_ok one match after reset", int'(sync_ok), 0);
        frame(64);
        wait_clk(3);
        check("R5", "sync_ok two matches after reset", int'(sync_ok), 1);
        check_out("R6", 1'b1);

        // R4: a large drift during hold keeps both outputs at zero.
        frame(100);
        frame(64);
        wait_clk(3);
        check("R3", "sync_ok after 36-bit jump", int'(sync_ok), 0);
        check_out("R4", 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule